// File: doc/BRIEF.md
# Guarded Branch Pair Resolver

Some guest branches are cracked into two host branches that share one logical PC: a conditional guard followed at once by an unconditional register-indirect jump. This block sits on the micro-op stream that leaves the translated-instruction buffer. It tags each such pair as it is dispatched. When the guard resolves, it squashes one of the two branches, so the back end sees exactly one control instruction at that PC. It also reports the guest-level branch outcome as one PC, one taken bit and one target.

The stream uses valid/ready. `in_head` marks the guard micro-op of a pair, and `in_depth` tells how many micro-ops the buffer holds. A guard is accepted only when its jump partner is already in the buffer. The pair then gets the tag shown on `head_tag`, and the next accepted micro-op is taken as the jump. One pair may be outstanding at a time, and the stream stalls until that pair resolves or is flushed. A resolution whose tag matches produces the outcome one cycle later. A flush drops any pair in progress.

Top module: `gbp_resolver`

## Requirements
- R1: After reset `out_valid`, `kill_guard` and `kill_jump` are 0, `in_ready` is 1 for a micro-op that is not a guard, and `head_tag` is 0.
- R2: A guard micro-op (`in_head`=1) is refused (`in_ready`=0) while `in_depth` is below 2. It is accepted when `in_depth` is 2 or more.
- R3: In the cycle after a guard is accepted, `in_ready` is 1 and the next micro-op is captured as the jump, carrying the jump target on `in_target`. After the jump is accepted, `in_ready` stays 0 until the pair resolves or is flushed.
- R4: If a matching resolution arrives with `res_taken`=1, then in the next cycle `out_valid`=1, `out_pc` is the pair's PC, `out_taken`=0, `out_target` is the guard's fall-through target, and `kill_jump`=1.
- R5: If a matching resolution arrives with `res_taken`=0, then in the next cycle `out_valid`=1, `out_taken`=1, `out_target` is the jump target, and `kill_guard`=1.
- R6: When `out_valid` is 1, exactly one of `kill_guard` and `kill_jump` is 1. Both are 0 when `out_valid` is 0, and `out_valid` lasts a single cycle.
- R7: A flush after the guard is accepted, before or after the jump, cancels the pair. No outcome follows, even if a resolution with the old tag arrives later, and the block is ready for a new micro-op.
- R8: A resolution whose tag differs from the outstanding pair's tag, or one that arrives when no complete pair is outstanding, produces no outcome.
- R9: Each accepted guard receives the value of `head_tag` at acceptance. The tag counts accepted guards, flushed ones included, modulo 2^TAGW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Pipeline flush, cancels a pair in progress |
| in_valid | input | 1 | Micro-op present at buffer head |
| in_head | input | 1 | Micro-op is the guard of a pair |
| in_depth | input | DEPTHW | Micro-ops currently in the buffer |
| in_pc | input | PCW | Logical PC of the micro-op |
| in_target | input | PCW | Guard: fall-through target; jump: register target |
| in_ready | output | 1 | Micro-op accepted this cycle when valid |
| head_tag | output | TAGW | Tag given to a guard accepted this cycle |
| res_valid | input | 1 | Guard resolution present |
| res_tag | input | TAGW | Tag of the resolving guard |
| res_taken | input | 1 | Guard condition taken |
| out_valid | output | 1 | Guest branch outcome valid |
| out_pc | output | PCW | PC of the guest branch |
| out_taken | output | 1 | Guest branch taken |
| out_target | output | PCW | Next guest PC |
| kill_guard | output | 1 | Guard becomes a no-op |
| kill_jump | output | 1 | Jump is squashed |

## Verification
The assertions rely on well-formed input: a guard is always followed by its own jump at the same PC, and never by another guard. The stimulus meets this by always presenting the jump with the guard's PC right after the guard. Resolutions are sent with the right tag, a wrong tag or no pair outstanding, and flushes land between the halves and after the jump. Both guard outcomes are swept over many PCs and targets, so the tag counter wraps.

// File: rtl/gbp_pkg.sv
package gbp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HALF  = 2'd1,
        ST_ARMED = 2'd2
    } pair_st_e;
endpackage

// File: rtl/gbp_pair_track.sv
module gbp_pair_track
    import gbp_pkg::*;
#(
    parameter int PCW    = 32,
    parameter int TAGW   = 3,
    parameter int DEPTHW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    input  logic              in_head,
    input  logic [DEPTHW-1:0] in_depth,
    input  logic [PCW-1:0]    in_pc,
    input  logic [PCW-1:0]    in_target,
    output logic              in_ready,
    output logic [TAGW-1:0]   head_tag,
    input  logic              res_valid,
    input  logic [TAGW-1:0]   res_tag,
    output logic              fire,
    output logic [PCW-1:0]    pair_pc,
    output logic [PCW-1:0]    pair_ft,
    output logic [PCW-1:0]    pair_jt
);
    localparam logic [DEPTHW-1:0] PAIR_SLOTS = DEPTHW'(2);

    typedef struct packed {
        pair_st_e        st;
        logic [TAGW-1:0] next_tag;
        logic [TAGW-1:0] tag;
        logic [PCW-1:0]  pc;
        logic [PCW-1:0]  ft;
        logic [PCW-1:0]  jt;
    } track_t;

    track_t s_q, s_d;
    logic   ready_c, accept_c, fire_c;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE:  ready_c = !(in_head && (in_depth < PAIR_SLOTS));
            ST_HALF:  ready_c = 1'b1;
            default:  ready_c = 1'b0;
        endcase
        ready_c  = ready_c && !flush;
        accept_c = in_valid && ready_c;
        fire_c   = (s_q.st == ST_ARMED) && res_valid && (res_tag == s_q.tag) && !flush;

        if (flush) begin
            s_d.st = ST_IDLE;
        end else begin
            unique case (s_q.st)
                ST_IDLE: begin
                    if (accept_c && in_head) begin
                        s_d.st       = ST_HALF;
                        s_d.tag      = s_q.next_tag;
                        s_d.next_tag = s_q.next_tag + TAGW'(1);
                        s_d.pc       = in_pc;
                        s_d.ft       = in_target;
                    end
                end
                ST_HALF: begin
                    if (accept_c) begin
                        s_d.st = ST_ARMED;
                        s_d.jt = in_target;
                    end
                end
                default: begin
                    if (fire_c) s_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, next_tag: '0, tag: '0, pc: '0, ft: '0, jt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready = ready_c;
    assign head_tag = s_q.next_tag;
    assign fire     = fire_c;
    assign pair_pc  = s_q.pc;
    assign pair_ft  = s_q.ft;
    assign pair_jt  = s_q.jt;
endmodule

// File: rtl/gbp_outcome.sv
module gbp_outcome #(
    parameter int PCW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fire,
    input  logic           guard_taken,
    input  logic [PCW-1:0] pair_pc,
    input  logic [PCW-1:0] pair_ft,
    input  logic [PCW-1:0] pair_jt,
    output logic           out_valid,
    output logic [PCW-1:0] out_pc,
    output logic           out_taken,
    output logic [PCW-1:0] out_target,
    output logic           kill_guard,
    output logic           kill_jump
);
    typedef struct packed {
        logic           vld;
        logic [PCW-1:0] pc;
        logic           taken;
        logic [PCW-1:0] tgt;
        logic           kg;
        logic           kj;
    } outc_t;

    outc_t o_q, o_d;

    always_comb begin
        o_d     = o_q;
        o_d.vld = fire;
        o_d.kg  = 1'b0;
        o_d.kj  = 1'b0;
        if (fire) begin
            o_d.pc = pair_pc;
            if (guard_taken) begin
                o_d.taken = 1'b0;
                o_d.tgt   = pair_ft;
                o_d.kj    = 1'b1;
            end else begin
                o_d.taken = 1'b1;
                o_d.tgt   = pair_jt;
                o_d.kg    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid  = o_q.vld;
    assign out_pc     = o_q.pc;
    assign out_taken  = o_q.taken;
    assign out_target = o_q.tgt;
    assign kill_guard = o_q.kg;
    assign kill_jump  = o_q.kj;
endmodule

// File: rtl/gbp_resolver.sv
module gbp_resolver #(
    parameter int PCW    = 32,
    parameter int TAGW   = 3,
    parameter int DEPTHW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    input  logic              in_head,
    input  logic [DEPTHW-1:0] in_depth,
    input  logic [PCW-1:0]    in_pc,
    input  logic [PCW-1:0]    in_target,
    output logic              in_ready,
    output logic [TAGW-1:0]   head_tag,
    input  logic              res_valid,
    input  logic [TAGW-1:0]   res_tag,
    input  logic              res_taken,
    output logic              out_valid,
    output logic [PCW-1:0]    out_pc,
    output logic              out_taken,
    output logic [PCW-1:0]    out_target,
    output logic              kill_guard,
    output logic              kill_jump
);
    logic           fire;
    logic [PCW-1:0] pair_pc, pair_ft, pair_jt;

    gbp_pair_track #(.PCW(PCW), .TAGW(TAGW), .DEPTHW(DEPTHW)) u_track (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .in_head(in_head), .in_depth(in_depth),
        .in_pc(in_pc), .in_target(in_target),
        .in_ready(in_ready), .head_tag(head_tag),
        .res_valid(res_valid), .res_tag(res_tag),
        .fire(fire), .pair_pc(pair_pc), .pair_ft(pair_ft), .pair_jt(pair_jt)
    );

    gbp_outcome #(.PCW(PCW)) u_out (
        .clk(clk), .rst_n(rst_n), .fire(fire), .guard_taken(res_taken),
        .pair_pc(pair_pc), .pair_ft(pair_ft), .pair_jt(pair_jt),
        .out_valid(out_valid), .out_pc(out_pc), .out_taken(out_taken),
        .out_target(out_target), .kill_guard(kill_guard), .kill_jump(kill_jump)
    );
endmodule

// File: rtl/gbp_resolver_chk.sv
module gbp_resolver_chk #(
    parameter int PCW    = 32,
    parameter int TAGW   = 3,
    parameter int DEPTHW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              in_valid,
    input logic              in_head,
    input logic [DEPTHW-1:0] in_depth,
    input logic              in_ready,
    input logic              res_valid,
    input logic              out_valid,
    input logic              out_taken,
    input logic              kill_guard,
    input logic              kill_jump
);
    AST_HEAD_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_head) |-> (in_depth >= DEPTHW'(2))); // R2

    AST_TAIL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_head && !flush) |=> (in_ready || flush)); // R3

    AST_ONE_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones({kill_guard, kill_jump}) == 1)); // R6

    AST_NO_KILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!kill_guard && !kill_jump)); // R6

    AST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R6

    AST_TAKEN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_taken == kill_guard)); // R4

    AST_FLUSH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid); // R7

    AST_NEEDS_RES: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> !out_valid); // R8
endmodule

bind gbp_resolver gbp_resolver_chk #(.PCW(PCW), .TAGW(TAGW), .DEPTHW(DEPTHW)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_head(in_head), .in_depth(in_depth), .in_ready(in_ready),
    .res_valid(res_valid), .out_valid(out_valid), .out_taken(out_taken),
    .kill_guard(kill_guard), .kill_jump(kill_jump)
);

// File: tb/tb_gbp_resolver.sv
`timescale 1ns/1ps
module tb_gbp_resolver;
    localparam int PCW = 16, TAGW = 3, DEPTHW = 4;

    logic              clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
    logic              in_valid = 1'b0, in_head = 1'b0;
    logic [DEPTHW-1:0] in_depth = '0;
    logic [PCW-1:0]    in_pc = '0, in_target = '0;
    logic              in_ready;
    logic [TAGW-1:0]   head_tag;
    logic              res_valid = 1'b0, res_taken = 1'b0;
    logic [TAGW-1:0]   res_tag = '0;
    logic              out_valid, out_taken, kill_guard, kill_jump;
    logic [PCW-1:0]    out_pc, out_target;

    int checks = 0, errors = 0;
    logic [TAGW-1:0] exp_tag = '0;

    always #5 clk = ~clk;

    gbp_resolver #(.PCW(PCW), .TAGW(TAGW), .DEPTHW(DEPTHW)) dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic send_head(input logic [PCW-1:0] pc, input logic [PCW-1:0] ft);
        in_valid = 1'b1; in_head = 1'b1; in_pc = pc; in_target = ft; in_depth = 4'd1;
        #1 chk("R2 head refused at depth 1", 32'(in_ready), 0);
        in_depth = 4'd2;
        #1 chk("R2 head accepted at depth 2", 32'(in_ready), 1);
        chk("R9 head tag", 32'(head_tag), 32'(exp_tag));
        step();
        exp_tag = exp_tag + TAGW'(1);
    endtask

    task automatic send_tail(input logic [PCW-1:0] pc, input logic [PCW-1:0] jt);
        in_head = 1'b0; in_pc = pc; in_target = jt; in_depth = 4'd1;
        #1 chk("R3 tail ready", 32'(in_ready), 1);
        step();
        in_valid = 1'b1; in_head = 1'b0; in_target = 16'hdead;
        #1 chk("R3 stall while armed", 32'(in_ready), 0);
        in_valid = 1'b0;
    endtask

    task automatic resolve(input logic [TAGW-1:0] t, input logic tk);
        res_valid = 1'b1; res_tag = t; res_taken = tk;
        step();
        res_valid = 1'b0;
    endtask

    task automatic full_pair(input logic [PCW-1:0] pc, input logic [PCW-1:0] ft,
                             input logic [PCW-1:0] jt, input logic tk, input logic wrong);
        logic [TAGW-1:0] t;
        t = exp_tag;
        send_head(pc, ft);
        send_tail(pc, jt);
        if (wrong) begin
            resolve(t ^ TAGW'(1), tk);
            chk("R8 wrong tag silent", 32'(out_valid), 0);
        end
        resolve(t, tk);
        chk(tk ? "R4 valid" : "R5 valid", 32'(out_valid), 1);
        chk("R4 pc", 32'(out_pc), 32'(pc));
        chk(tk ? "R4 taken" : "R5 taken", 32'(out_taken), tk ? 0 : 1);
        chk(tk ? "R4 target" : "R5 target", 32'(out_target), tk ? 32'(ft) : 32'(jt));
        chk(tk ? "R4 kill_jump" : "R5 kill_jump", 32'(kill_jump), tk ? 1 : 0);
        chk(tk ? "R4 kill_guard" : "R5 kill_guard", 32'(kill_guard), tk ? 0 : 1);
        step();
        chk("R6 single pulse", 32'(out_valid), 0);
        chk("R6 kills clear", 32'({kill_guard, kill_jump}), 0);
        in_valid = 1'b1; in_head = 1'b0;
        #1 chk("R3 ready after resolve", 32'(in_ready), 1);
        in_valid = 1'b0;
    endtask

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #23 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 kills", 32'({kill_guard, kill_jump}), 0);
        chk("R1 head_tag", 32'(head_tag), 0);
        in_valid = 1'b1;
        #1 chk("R1 ready", 32'(in_ready), 1);
        in_valid = 1'b0;

        // R8: resolution with no pair outstanding
        resolve(3'd0, 1'b0);
        chk("R8 idle resolution silent", 32'(out_valid), 0);

        // main sweep, both guard outcomes, tag wraps
        for (int i = 0; i < 20; i++) begin
            full_pair(16'(16'h1000 + i * 4), 16'(16'h1004 + i * 4),
                      16'(16'h8000 + i * 37), 1'(i % 2), (i % 3) == 0);
        end

        // R7: flush between halves
        for (int k = 0; k < 2; k++) begin
            logic [TAGW-1:0] t;
            t = exp_tag;
            send_head(16'h2222, 16'h2226);
            in_valid = 1'b0; flush = 1'b1;
            step();
            flush = 1'b0;
            if (k == 1) begin
                // stale tail then resolution: no pair should arm
                in_valid = 1'b1; in_head = 1'b0; in_target = 16'h3333;
                step();
                in_valid = 1'b0;
            end
            resolve(t, 1'b1);
            chk("R7 no outcome after split flush", 32'(out_valid), 0);
            in_valid = 1'b1; in_head = 1'b0;
            #1 chk("R7 ready after flush", 32'(in_ready), 1);
            in_valid = 1'b0;
        end

        // R7: flush after jump, resolution in the flush cycle and after
        begin
            logic [TAGW-1:0] t;
            t = exp_tag;
            send_head(16'h4444, 16'h4448);
            send_tail(16'h4444, 16'h5555);
            flush = 1'b1; res_valid = 1'b1; res_tag = t; res_taken = 1'b0;
            step();
            flush = 1'b0; res_valid = 1'b0;
            chk("R7 flush beats resolution", 32'(out_valid), 0);
            resolve(t, 1'b0);
            chk("R7 stale tag silent", 32'(out_valid), 0);
        end

        // R9: tag continues after flushed pairs
        full_pair(16'h6000, 16'h6004, 16'h7000, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule